// File: doc/BRIEF.md
# Level-Sensitive Shared Interrupt Pending Tracker

This block holds the pending state for a bank of level-sensitive shared peripheral interrupts. An interrupt can be pending for three independent reasons. Its input wire can be high. A message write can have latched it. A software register write can have latched it. The two latched sources are stored in separate vectors. A clear that arrives through one path therefore never removes pending state that the other path created. An acknowledge/activate strobe retires both latched sources for one interrupt. A wire that is still high keeps the interrupt pending after that.

Each of the five operations (message-set, message-clear, software-set, software-clear, acknowledge) carries its own valid strobe and interrupt ID. The ID is `ID_W` bits wide, at most 16, and must be large enough to address `NUM_IRQ` interrupts. Operations whose ID is `NUM_IRQ` or higher are dropped. Nothing gates pending on group or enable controls. The block outputs a registered pending vector and a registered single-bit readback for an ID presented on a separate read port.

Top module: `spi_pend_track`

## Requirements
- R1: While `rst` is high at a clock edge, both latch vectors are cleared. After that edge, `pend_vec` and `rd_pend` are 0.
- R2: After each edge, `pend_vec[i]` equals `lvl_in[i]` sampled at that edge, OR the message latch, OR the software latch. The latch values used are the ones just updated at that edge.
- R3: A message-set for ID i sets the message latch of i. A software-clear for i leaves the message latch of i unchanged.
- R4: A software-set for ID i sets the software latch of i. A message-clear for i leaves the software latch of i unchanged.
- R5: A message-clear for i, with no message-set for i, clears only the message latch of i. A software-clear for i, with no software-set for i, clears only the software latch of i.
- R6: When a set and a clear (or an acknowledge) for the same source and ID arrive in the same cycle, that source's latch ends up set.
- R7: An acknowledge for i clears both latches of i, except where a same-cycle set applies. A high `lvl_in[i]` still makes i pending.
- R8: Any operation whose ID is NUM_IRQ or above changes no latch and no output bit.
- R9: `rd_pend` after an edge equals the value `pend_vec[rd_id]` takes at that same edge, with `rd_id` sampled at that edge. It is 0 when `rd_id` is NUM_IRQ or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_in | input | NUM_IRQ | Interrupt wire levels |
| msg_set_vld | input | 1 | Message-set strobe |
| msg_set_id | input | ID_W | Message-set interrupt ID |
| msg_clr_vld | input | 1 | Message-clear strobe |
| msg_clr_id | input | ID_W | Message-clear interrupt ID |
| sw_set_vld | input | 1 | Software-set strobe |
| sw_set_id | input | ID_W | Software-set interrupt ID |
| sw_clr_vld | input | 1 | Software-clear strobe |
| sw_clr_id | input | ID_W | Software-clear interrupt ID |
| ack_vld | input | 1 | Acknowledge/activate strobe |
| ack_id | input | ID_W | Acknowledge interrupt ID |
| rd_id | input | ID_W | Readback interrupt ID |
| pend_vec | output | NUM_IRQ | Registered combined pending vector |
| rd_pend | output | 1 | Registered combined pending bit for rd_id |

## Verification
A latch bit that is wrong shows up on `pend_vec` at the edge right after the operation. It shows up only while the wire level for that interrupt is low, so the checks drive the level low whenever latch state has to be observed. A latch that one path cleared wrongly, or a set that did not reach its latch, stays wrong until the next set, so a follow-up readback of that ID exposes it one cycle later. A decoder fault on out-of-range IDs corrupts some in-range bit, which the full pending vector reveals in the same cycle.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum int {
    OP_MSET = 0,
    OP_MCLR = 1,
    OP_SSET = 2,
    OP_SCLR = 3,
    OP_ACK  = 4
  } spt_op_e;

  localparam int NUM_OP = 5;
endpackage

// File: rtl/spt_id_dec.sv
module spt_id_dec #(
  parameter int N   = 32,
  parameter int IDW = 6
) (
  input  logic           vld,
  input  logic [IDW-1:0] id,
  output logic [N-1:0]   hot
);
  always_comb begin
    hot = '0;
    for (int i = 0; i < N; i++) begin
      if (vld && (id == IDW'(i))) hot[i] = 1'b1;
    end
  end

  always_comb begin
    // R8
    if (vld && (int'(id) >= N)) begin
      oor_drop_chk: assert (hot == '0);
    end
  end
endmodule

// File: rtl/spt_src_latch.sv
module spt_src_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_hot,
  input  logic [N-1:0] clr_hot,
  input  logic [N-1:0] ack_hot,
  output logic [N-1:0] q,
  output logic [N-1:0] nxt
);
  always_comb nxt = set_hot | (q & ~clr_hot & ~ack_hot);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_hot) |=> ((q & $past(set_hot)) == $past(set_hot)));

  // R5
  clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_hot & ~set_hot)) |=> ((q & $past(clr_hot & ~set_hot)) == '0));

  // R7
  ack_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ack_hot & ~set_hot)) |=> ((q & $past(ack_hot & ~set_hot)) == '0));
endmodule

// File: rtl/spi_pend_track.sv
module spi_pend_track #(
  parameter int NUM_IRQ = 32,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] lvl_in,
  input  logic               msg_set_vld,
  input  logic [ID_W-1:0]    msg_set_id,
  input  logic               msg_clr_vld,
  input  logic [ID_W-1:0]    msg_clr_id,
  input  logic               sw_set_vld,
  input  logic [ID_W-1:0]    sw_set_id,
  input  logic               sw_clr_vld,
  input  logic [ID_W-1:0]    sw_clr_id,
  input  logic               ack_vld,
  input  logic [ID_W-1:0]    ack_id,
  input  logic [ID_W-1:0]    rd_id,
  output logic [NUM_IRQ-1:0] pend_vec,
  output logic               rd_pend
);
  import spt_pkg::*;

  localparam int MIN_ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  if (ID_W < MIN_ID_W || ID_W > 16) begin : g_bad_idw
    $error("ID_W out of range for NUM_IRQ");
  end

  logic [NUM_OP-1:0]              op_vld;
  logic [NUM_OP-1:0][ID_W-1:0]    op_id;
  logic [NUM_OP-1:0][NUM_IRQ-1:0] op_hot;

  always_comb begin
    op_vld[OP_MSET] = msg_set_vld;  op_id[OP_MSET] = msg_set_id;
    op_vld[OP_MCLR] = msg_clr_vld;  op_id[OP_MCLR] = msg_clr_id;
    op_vld[OP_SSET] = sw_set_vld;   op_id[OP_SSET] = sw_set_id;
    op_vld[OP_SCLR] = sw_clr_vld;   op_id[OP_SCLR] = sw_clr_id;
    op_vld[OP_ACK]  = ack_vld;      op_id[OP_ACK]  = ack_id;
  end

  for (genvar g = 0; g < NUM_OP; g++) begin : g_dec
    spt_id_dec #(.N(NUM_IRQ), .IDW(ID_W)) u_dec (
      .vld (op_vld[g]),
      .id  (op_id[g]),
      .hot (op_hot[g])
    );
  end

  logic [NUM_IRQ-1:0] msg_q, msg_nxt, sw_q, sw_nxt, comb_nxt;

  spt_src_latch #(.N(NUM_IRQ)) u_msg (
    .clk     (clk),
    .rst     (rst),
    .set_hot (op_hot[OP_MSET]),
    .clr_hot (op_hot[OP_MCLR]),
    .ack_hot (op_hot[OP_ACK]),
    .q       (msg_q),
    .nxt     (msg_nxt)
  );

  spt_src_latch #(.N(NUM_IRQ)) u_sw (
    .clk     (clk),
    .rst     (rst),
    .set_hot (op_hot[OP_SSET]),
    .clr_hot (op_hot[OP_SCLR]),
    .ack_hot (op_hot[OP_ACK]),
    .q       (sw_q),
    .nxt     (sw_nxt)
  );

  always_comb comb_nxt = lvl_in | msg_nxt | sw_nxt;

  logic rd_bit;
  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (rd_id == ID_W'(i)) rd_bit = comb_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vec <= '0;
      rd_pend  <= 1'b0;
    end else begin
      pend_vec <= comb_nxt;
      rd_pend  <= rd_bit;
    end
  end

  // R3
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_hot[OP_MCLR] | op_hot[OP_ACK]) == '0)
      |=> ((msg_q & $past(msg_q)) == $past(msg_q)));

  // R4
  sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_hot[OP_SCLR] | op_hot[OP_ACK]) == '0)
      |=> ((sw_q & $past(sw_q)) == $past(sw_q)));

  // R2
  lvl_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (|lvl_in) |=> ((pend_vec & $past(lvl_in)) == $past(lvl_in)));

  // R2
  latch_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (|(msg_q | sw_q)) |-> ((pend_vec & (msg_q | sw_q)) == (msg_q | sw_q)));

  // R9
  rd_oor_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_id) >= NUM_IRQ) |=> !rd_pend);
endmodule

// File: tb/spi_pend_track_test.sv
`timescale 1ns/1ps
module spi_pend_track_test;
  localparam int N  = 8;
  localparam int IW = 4;
  localparam int MSET = 1, MCLR = 2, SSET = 4, SCLR = 8, ACK = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] lvl_in = '0;
  logic msg_set_vld = 0, msg_clr_vld = 0, sw_set_vld = 0, sw_clr_vld = 0, ack_vld = 0;
  logic [IW-1:0] msg_set_id = '0, msg_clr_id = '0, sw_set_id = '0, sw_clr_id = '0, ack_id = '0;
  logic [IW-1:0] rd_id = '0;
  logic [N-1:0] pend_vec;
  logic rd_pend;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mref = '0;
  logic [N-1:0] sref = '0;

  always #2 clk = ~clk;

  spi_pend_track #(.NUM_IRQ(N), .ID_W(IW)) uut (
    .clk(clk), .rst(rst), .lvl_in(lvl_in),
    .msg_set_vld(msg_set_vld), .msg_set_id(msg_set_id),
    .msg_clr_vld(msg_clr_vld), .msg_clr_id(msg_clr_id),
    .sw_set_vld(sw_set_vld), .sw_set_id(sw_set_id),
    .sw_clr_vld(sw_clr_vld), .sw_clr_id(sw_clr_id),
    .ack_vld(ack_vld), .ack_id(ack_id),
    .rd_id(rd_id), .pend_vec(pend_vec), .rd_pend(rd_pend)
  );

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive one cycle of operations (all on the same ID), then compare with the model.
  task automatic step(input int ops, input int id, input logic [N-1:0] lvl,
                      input int rid, input string tag);
    logic [N-1:0] ep;
    logic er;
    msg_set_vld = ops[0]; msg_clr_vld = ops[1]; sw_set_vld = ops[2];
    sw_clr_vld = ops[3]; ack_vld = ops[4];
    msg_set_id = IW'(id); msg_clr_id = IW'(id); sw_set_id = IW'(id);
    sw_clr_id = IW'(id); ack_id = IW'(id);
    lvl_in = lvl; rd_id = IW'(rid);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      logic h;
      h = (id == i);
      mref[i] = (ops[0] & h) | (mref[i] & ~(ops[1] & h) & ~(ops[4] & h));
      sref[i] = (ops[2] & h) | (sref[i] & ~(ops[3] & h) & ~(ops[4] & h));
    end
    ep = lvl | mref | sref;
    er = (rid < N) ? ep[rid] : 1'b0;
    @(negedge clk);
    chk(pend_vec, ep, {tag, " pend_vec"});
    chk(N'(rd_pend), N'(er), {tag, " rd_pend"});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pend_vec, '0, "R1 pend_vec");
    chk(N'(rd_pend), '0, "R1 rd_pend");
    rst = 1'b0;

    // R3 message set survives software clear
    step(MSET, 3, '0, 3, "R3");
    step(SCLR, 3, '0, 3, "R3");
    chk(N'(rd_pend), N'(1), "R3 msg latch kept");
    // R4 software set survives message clear
    step(SSET, 5, '0, 5, "R4");
    step(MCLR, 5, '0, 5, "R4");
    chk(N'(rd_pend), N'(1), "R4 sw latch kept");
    // R5 each clear removes only its own source
    step(MCLR, 3, '0, 3, "R5");
    chk(N'(rd_pend), N'(0), "R5 msg clear");
    step(SCLR, 5, '0, 5, "R5");
    chk(pend_vec, '0, "R5 sw clear");
    // R6 set beats clear and ack
    step(MSET | MCLR, 2, '0, 2, "R6");
    chk(N'(rd_pend), N'(1), "R6 msg set wins");
    step(SSET | SCLR | ACK, 6, '0, 6, "R6");
    chk(pend_vec, 8'b0100_0100, "R6 sw set wins");
    // R7 ack clears both latches, wire still shows
    step(ACK, 2, '0, 2, "R7");
    step(ACK, 6, '0, 6, "R7");
    step(MSET, 1, '0, 1, "R7");
    step(SSET, 1, 8'b0000_0010, 1, "R7");
    step(ACK, 1, 8'b0000_0010, 1, "R7");
    chk(N'(rd_pend), N'(1), "R7 wire keeps pending");
    step(0, 0, '0, 1, "R7");
    chk(N'(rd_pend), N'(0), "R7 latches gone");
    // R8 out-of-range IDs dropped
    step(MSET | SSET, 12, '0, 4, "R8");
    chk(pend_vec, '0, "R8 oor set");
    step(MSET, 0, '0, 0, "R8");
    step(ACK | MCLR | SCLR, 8, '0, 0, "R8");
    chk(pend_vec, 8'b0000_0001, "R8 oor clear");
    // R9 out-of-range read returns 0
    step(0, 0, 8'hFF, 9, "R9");
    chk(N'(rd_pend), N'(0), "R9 oor read");

    // R2 R9 sweep: every ID (incl. out of range) with every op combination
    for (int k = 0; k < 16 * 32; k++) begin
      int id;
      int ops;
      logic [N-1:0] lv;
      id  = k / 32;
      ops = k % 32;
      lv  = N'((k * 37) >> 2) & N'((k % 3 == 0) ? 8'h00 : 8'h5A);
      step(ops, id, lv, (k * 5) % 16, "R2/R9 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule